// File: doc/BRIEF.md
# Interrupt Entry Shadow Context Store

The block holds one snapshot of a small processor's working context: the accumulator, the flags word and the bank pointer. The processor has two interrupt priority levels. When an interrupt is taken at a level whose capture is enabled, the live values are copied into the shadow set on the same clock edge as the entry strobe. A fast return copies the shadow set back to the restore outputs and raises a one-cycle valid pulse on the following cycle. A return without the fast option does nothing to the block.

There is only one shadow set for both levels. If an urgent interrupt arrives while a less urgent handler still has an unconsumed snapshot, the new capture replaces it and the older context is lost. The block records this in a sticky error flag, which is cleared by reset or by a clear strobe. It also reports which level wrote the current snapshot and whether a snapshot is waiting to be consumed. Software is expected to turn off low-level capture whenever nesting can happen.

Top module: `irq_shadow_ctx`

## Requirements
- R1: After reset the shadow registers are zero, the snapshot-held flag, the owner level, the overwrite flag and the restore valid pulse are all 0.
- R2: An entry strobe at a level whose enable is high captures acc_i, flags_i and bank_i into the shadow set on that clock edge. If both entry strobes are high in the same cycle, the high level is treated as the one taken.
- R3: An entry strobe at a level whose enable is low leaves the shadow set, the owner and the held flag unchanged.
- R4: One cycle after fast_ret_i, rst_valid_o is high for exactly one cycle and rst_acc_o, rst_flags_o and rst_bank_o carry the shadow values. The restore outputs hold their values at other times.
- R5: A fast return consumes the snapshot, so snap_held_o goes to 0. A return with plain_ret_i changes no output.
- R6: A capture made while snap_held_o is 1 sets ovr_err_o. A fast return does not clear it. It stays set until err_clr_i or reset.
- R7: snap_lvl_o is 1 when the current snapshot was written by a high-level entry and 0 when it was written by a low-level entry.
- R8: A capture and a fast return in the same cycle restore the old snapshot and store the new one. snap_held_o then stays 1 and no overwrite is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_i | input | DW | Live working register |
| flags_i | input | SW | Live status register |
| bank_i | input | BW | Live bank select register |
| lo_en_i | input | 1 | Capture enable for low-level entry |
| hi_en_i | input | 1 | Capture enable for high-level entry |
| lo_entry_i | input | 1 | Low-level interrupt entry strobe |
| hi_entry_i | input | 1 | High-level interrupt entry strobe |
| fast_ret_i | input | 1 | Return that restores the context |
| plain_ret_i | input | 1 | Return that does not restore |
| err_clr_i | input | 1 | Clears the overwrite flag |
| rst_acc_o | output | DW | Restored working register |
| rst_flags_o | output | SW | Restored status register |
| rst_bank_o | output | BW | Restored bank select |
| rst_valid_o | output | 1 | One-cycle pulse marking restored values |
| snap_held_o | output | 1 | A snapshot is waiting to be consumed |
| snap_lvl_o | output | 1 | Level that wrote the snapshot (1 = high) |
| ovr_err_o | output | 1 | Sticky flag for a lost snapshot |

## Verification
The hardest case to reach is a preempted low-level handler whose context is lost. To produce it, the bench enables low-level capture, takes a low-level entry, and then takes a high-level entry before any fast return. It then performs two fast returns. A reference stack in the bench shows that the second restore returns the high-level values instead of the low-level ones, and the bench checks that the error flag stays set until it is cleared. A cycle that has a capture and a fast return together is also driven, to check that the order of the two operations is correct.

// File: rtl/irq_shadow_ctx.sv
module irq_shadow_ctx #(
  parameter int DW = 8,
  parameter int SW = 8,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] acc_i,
  input  logic [SW-1:0] flags_i,
  input  logic [BW-1:0] bank_i,
  input  logic          lo_en_i,
  input  logic          hi_en_i,
  input  logic          lo_entry_i,
  input  logic          hi_entry_i,
  input  logic          fast_ret_i,
  input  logic          plain_ret_i,
  input  logic          err_clr_i,
  output logic [DW-1:0] rst_acc_o,
  output logic [SW-1:0] rst_flags_o,
  output logic [BW-1:0] rst_bank_o,
  output logic          rst_valid_o,
  output logic          snap_held_o,
  output logic          snap_lvl_o,
  output logic          ovr_err_o
);
  logic [DW-1:0] sh_acc;
  logic [SW-1:0] sh_flags;
  logic [BW-1:0] sh_bank;

  wire hi_cap = hi_entry_i & hi_en_i;
  wire lo_cap = lo_entry_i & lo_en_i & ~hi_entry_i;
  wire cap    = hi_cap | lo_cap;
  wire clash  = cap & snap_held_o & ~fast_ret_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_acc   <= '0;
      sh_flags <= '0;
      sh_bank  <= '0;
      snap_lvl_o <= 1'b0;
    end else if (cap) begin
      sh_acc   <= acc_i;
      sh_flags <= flags_i;
      sh_bank  <= bank_i;
      snap_lvl_o <= hi_cap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap_held_o <= 1'b0;
    else if (cap) snap_held_o <= 1'b1;
    else if (fast_ret_i) snap_held_o <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_err_o <= 1'b0;
    else if (clash) ovr_err_o <= 1'b1;
    else if (err_clr_i) ovr_err_o <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_acc_o   <= '0;
      rst_flags_o <= '0;
      rst_bank_o  <= '0;
      rst_valid_o <= 1'b0;
    end else begin
      rst_valid_o <= fast_ret_i;
      if (fast_ret_i) begin
        rst_acc_o   <= sh_acc;
        rst_flags_o <= sh_flags;
        rst_bank_o  <= sh_bank;
      end
    end
  end

  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_entry_i && hi_en_i && !fast_ret_i) |=> (snap_held_o && snap_lvl_o));
  a_r3_disabled_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (!(hi_entry_i && hi_en_i) && !(lo_entry_i && lo_en_i) && !fast_ret_i)
      |=> ($stable(snap_held_o) && $stable(snap_lvl_o)));
  a_r4_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_valid_o |-> $past(fast_ret_i));
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fast_ret_i) |-> ($stable(rst_acc_o) && $stable(rst_bank_o) && $stable(rst_flags_o)));
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_err_o && !err_clr_i) |=> ovr_err_o);
  a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_held_o && !fast_ret_i && hi_entry_i && hi_en_i) |=> ovr_err_o);
  a_r5_consume: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_ret_i && !hi_entry_i && !lo_entry_i) |=> !snap_held_o);
endmodule

// File: tb/irq_shadow_ctx_tb.sv
module irq_shadow_ctx_tb;
  logic clk = 0, rst_n = 0;
  logic [7:0] acc, flg; logic [3:0] bnk;
  logic lo_en, hi_en, lo_e, hi_e, fr, pr, clr;
  logic [7:0] r_acc, r_flg; logic [3:0] r_bnk;
  logic r_v, held, lvl, err;
  int checks = 0, fails = 0;
  logic [19:0] stk [0:3]; int sp = 0;

  always #10 clk = ~clk;

  irq_shadow_ctx u_dut (.clk(clk), .rst_n(rst_n), .acc_i(acc), .flags_i(flg), .bank_i(bnk),
    .lo_en_i(lo_en), .hi_en_i(hi_en), .lo_entry_i(lo_e), .hi_entry_i(hi_e),
    .fast_ret_i(fr), .plain_ret_i(pr), .err_clr_i(clr),
    .rst_acc_o(r_acc), .rst_flags_o(r_flg), .rst_bank_o(r_bnk), .rst_valid_o(r_v),
    .snap_held_o(held), .snap_lvl_o(lvl), .ovr_err_o(err));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin fails++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  task automatic idle(); lo_e = 0; hi_e = 0; fr = 0; pr = 0; clr = 0; endtask
  task automatic step(); @(posedge clk); #5; idle(); endtask
  task automatic live(logic [7:0] a, logic [7:0] f, logic [3:0] b); acc = a; flg = f; bnk = b; endtask
  task automatic push(); stk[sp] = {acc, flg, bnk}; sp++; endtask

  task automatic t_reset();
    chk("R1 restore", {r_v, r_acc, r_flg, r_bnk}, 0);
    chk("R1 status", {held, lvl, err}, 0);
  endtask

  task automatic t_low_entry_return();
    live(8'h11, 8'h22, 4'h3); lo_e = 1; push(); step();
    chk("R2 held", held, 1); chk("R7 low level", lvl, 0);
    live(8'hFF, 8'hFF, 4'hF); pr = 1; step();
    chk("R5 plain return no valid", r_v, 0); chk("R5 plain still held", held, 1);
    fr = 1; step();
    sp--;
    chk("R4 valid", r_v, 1); chk("R4 values", {r_acc, r_flg, r_bnk}, stk[sp]);
    chk("R5 consumed", held, 0); chk("R6 no error", err, 0);
    step(); chk("R4 one cycle", r_v, 0); chk("R4 hold", {r_acc, r_flg, r_bnk}, stk[sp]);
  endtask

  task automatic t_disabled();
    lo_en = 0; live(8'h55, 8'h66, 4'h7); lo_e = 1; step();
    chk("R3 disabled no capture", held, 0);
    fr = 1; step();
    chk("R3 shadow unchanged", {r_acc, r_flg, r_bnk}, {8'h11, 8'h22, 4'h3});
    lo_en = 1;
  endtask

  task automatic t_nested();
    live(8'hA1, 8'hA2, 4'h1); lo_e = 1; push(); step();
    live(8'hB1, 8'hB2, 4'h2); hi_e = 1; push(); step();
    chk("R6 overwrite flagged", err, 1); chk("R7 high level", lvl, 1);
    fr = 1; step(); sp--;
    chk("R4 inner restore", {r_acc, r_flg, r_bnk}, stk[sp]);
    chk("R6 sticky after return", err, 1);
    fr = 1; step(); sp--;
    chk("R6 low context lost", {r_acc, r_flg, r_bnk} != stk[sp], 1);
    clr = 1; step(); chk("R6 cleared", err, 0);
  endtask

  task automatic t_both_and_same_cycle();
    live(8'hC1, 8'hC2, 4'h4); lo_e = 1; hi_e = 1; step();
    chk("R2 simultaneous high wins", lvl, 1);
    live(8'hD1, 8'hD2, 4'h5); lo_e = 1; fr = 1; step();
    chk("R8 old restored", {r_acc, r_flg, r_bnk}, {8'hC1, 8'hC2, 4'h4});
    chk("R8 still held", held, 1); chk("R8 no error", err, 0);
    fr = 1; step();
    chk("R8 new restored", {r_acc, r_flg, r_bnk}, {8'hD1, 8'hD2, 4'h5});
  endtask

  initial begin
    #4000000; fails++; $display("FAIL watchdog");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails); $finish;
  end

  initial begin
    idle(); lo_en = 1; hi_en = 1; live(0, 0, 0);
    #35; t_reset(); rst_n = 1; step();
    t_reset();
    t_low_entry_return();
    t_disabled();
    t_nested();
    t_both_and_same_cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule